// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus: it behaves as a small byte-wide non-volatile memory with an 8-bit word pointer. The bus clock and data lines are brought into the system clock domain through two flip-flop stages each. Start, repeated start and stop are then detected from the synchronized levels, and the data line is driven only as an open-drain pull-down through an output enable.

A master writes by sending the device address with the direction bit low, a word address and one or more data bytes, then a stop. The data bytes wait in a small page buffer and reach the array only when the stop arrives. The device is then busy for a programmable number of system clocks. A master reads either from the current pointer, or by first setting the pointer in write mode and issuing a repeated start with the direction bit high. It keeps receiving bytes for as long as it acknowledges them.

Top module: `eeprom_target`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and the device is ready, so its address is acknowledged at once.
- R2: The first byte after a start is the control byte: bits 7..1 are the device address (default 7'b1010000) and bit 0 is the direction (1 = read, 0 = write). On a match the target pulls SDA low during the ninth clock.
- R3: A control byte with any other address is not acknowledged, and every later byte is ignored until the next start.
- R4: In write mode the target acknowledges the word address byte and every data byte.
- R5: Data bytes are stored at consecutive addresses from the word address. They are committed to the array when the stop arrives, and a later read returns them.
- R6: A write that ends in a repeated start instead of a stop commits nothing and starts no busy period.
- R7: A random read (write-mode control byte, word address, repeated start, read-mode control byte) returns the byte at that word address.
- R8: During a read the master drives the ninth bit. A low bit makes the target send the next byte. A high bit ends the read, and the target leaves SDA released.
- R9: The word pointer advances after every data byte, on both write and read, and wraps from the last array location to 0.
- R10: After a stop that ends a write with at least one data byte, the target does not acknowledge its address for WRITE_CYCLES system clocks. After that time it acknowledges again.
- R11: The target changes SDA only while SCL is low. A stop in the middle of a byte aborts the transfer, with nothing written and no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level, asynchronous |
| sda_in | input | 1 | Bus data level, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A stop and the start of the array commit fall in the same cycle as the launch of the busy period. A master that polls at once after a write therefore meets the refusal of its address within the same burst of events. The bench provokes this by polling straight after the write stop and judges the NACK. It then polls again after the write cycle has elapsed and expects an ACK. It also ends a write with a repeated start, so that start detection and a pending page fall together. It then checks that the old byte is still there and that no busy period follows.

// File: rtl/eeprom_target.sv
module eeprom_target #(
  parameter logic [6:0] DEV_ADDR     = 7'b1010000,
  parameter int         DEPTH        = 256,
  parameter int         PAGE         = 16,
  parameter int         WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDAT, S_ACK, S_RDAT, S_MACK} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire sta  = scl_s & scl_d & sda_d & ~sda_s;
  wire stp  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise = scl_s & ~scl_d;
  wire fall = ~scl_s & scl_d;

  st_t             st, nx;
  logic [3:0]      bits;
  logic [7:0]      sh;
  logic [AW-1:0]   ptr, base;
  logic [PW-1:0]   widx;
  logic            pfull, wr_pend;
  logic [BW-1:0]   bcnt;
  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];

  wire       busy   = bcnt != '0;
  wire       done8  = fall && bits == 4'd8;
  wire [7:0] rbyte  = mem[ptr];
  wire       commit = stp && wr_pend;
  wire       bwrite = !stp && !sta && st == S_WDAT && done8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_in}; sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (bwrite) pbuf[widx] <= sh;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pfull || i < int'(widx)) mem[base + AW'(i)] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nx <= S_IDLE; bits <= '0; sh <= '0; sda_oe <= 1'b0;
      ptr <= '0; base <= '0; widx <= '0; pfull <= 1'b0; wr_pend <= 1'b0; bcnt <= '0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (stp) begin
        st <= S_IDLE; sda_oe <= 1'b0; wr_pend <= 1'b0;
        if (wr_pend) bcnt <= BW'(WRITE_CYCLES);
      end else if (sta) begin
        st <= S_DEV; bits <= '0; sda_oe <= 1'b0; wr_pend <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_ADDR, S_WDAT: begin
            if (rise) begin sh <= {sh[6:0], sda_s}; bits <= bits + 1'b1; end
            if (done8) begin
              st <= S_ACK; sda_oe <= 1'b1; nx <= S_WDAT;
              if (st == S_DEV) begin
                if (sh[7:1] != DEV_ADDR || busy) begin st <= S_IDLE; sda_oe <= 1'b0; end
                nx <= sh[0] ? S_RDAT : S_ADDR;
              end else if (st == S_ADDR) begin
                ptr <= AW'(sh); base <= AW'(sh); widx <= '0; pfull <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1; widx <= widx + 1'b1; wr_pend <= 1'b1;
                if (widx == PW'(PAGE - 1)) pfull <= 1'b1;
              end
            end
          end
          S_ACK, S_MACK: begin
            if (rise && st == S_MACK) sh[0] <= sda_s;
            if (fall) begin
              bits <= '0;
              if ((st == S_ACK && nx == S_RDAT) || (st == S_MACK && !sh[0])) begin
                st <= S_RDAT; sh <= rbyte; sda_oe <= ~rbyte[7]; ptr <= ptr + 1'b1;
              end else begin
                st <= (st == S_ACK) ? nx : S_IDLE; sda_oe <= 1'b0;
              end
            end
          end
          S_RDAT: begin
            if (rise) bits <= bits + 1'b1;
            if (done8) begin
              st <= S_MACK; sda_oe <= 1'b0; bits <= '0;
            end else if (fall) begin
              sda_oe <= ~sh[6]; sh <= {sh[6:0], 1'b0};
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(sta || stp)));
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  p_master_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK) |-> !sda_oe);
  p_busy_from_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stp));
  p_busy_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && busy) |=> !sda_oe);
endmodule

// File: tb/test_eeprom_target.sv
`timescale 1ns/1ps
module test_eeprom_target;
  localparam int WC = 400;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  eeprom_target #(.WRITE_CYCLES(WC)) i_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  localparam logic [15:0] VEC [5] = '{16'h033C, 16'h10A5, 16'h7E00, 16'hC1FF, 16'h405C};

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_c;
    sda_m = 1'b1; tick(5); scl = 1'b1; tick(10); sda_m = 1'b0; tick(10); scl = 1'b0; tick(5);
  endtask

  task automatic stop_c;
    scl = 1'b0; tick(5); sda_m = 1'b0; tick(5); scl = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(5); sda_m = b[i]; tick(5); scl = 1'b1; tick(10);
    end
    scl = 1'b0; tick(5); sda_m = 1'b1; tick(5); scl = 1'b1; tick(5);
    ack = sda_line; tick(5); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b0; tick(10); scl = 1'b1; tick(5); b = {b[6:0], sda_line}; tick(5);
    end
    scl = 1'b0; tick(5); sda_m = ~mack; tick(5); scl = 1'b1; tick(10);
    scl = 1'b0; tick(5); sda_m = 1'b1;
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d, input string req);
    logic ack;
    start_c;
    send_byte(8'hA0, ack); check({req, " ctl ack R2"}, {7'd0, ack}, 8'h00);
    send_byte(a, ack);     check({req, " addr ack R4"}, {7'd0, ack}, 8'h00);
    send_byte(d, ack);     check({req, " data ack R4"}, {7'd0, ack}, 8'h00);
    stop_c;
  endtask

  task automatic read1(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic ack; logic [7:0] b;
    start_c; send_byte(8'hA0, ack); send_byte(a, ack);
    start_c; send_byte(8'hA1, ack); check({req, " read ctl ack R7"}, {7'd0, ack}, 8'h00);
    recv_byte(1'b0, b); check(req, b, exp);
    stop_c;
  endtask

  initial begin
    logic ack; logic [7:0] b;
    tick(5);
    check("R1 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1; tick(5);
    start_c; send_byte(8'hA0, ack); check("R1 ready after reset", {7'd0, ack}, 8'h00); stop_c;

    foreach (VEC[k]) begin
      write1(VEC[k][15:8], VEC[k][7:0], "R5 vector");
      tick(WC + 50);
      read1(VEC[k][15:8], VEC[k][7:0], "R5 R7 vector readback");
    end

    // R3: foreign address refused, following bytes ignored
    start_c;
    send_byte(8'hA2, ack); check("R3 foreign addr nack", {7'd0, ack}, 8'h01);
    send_byte(8'h00, ack); check("R3 later byte ignored", {7'd0, ack}, 8'h01);
    stop_c;

    // R6: write ended by repeated start commits nothing
    start_c; send_byte(8'hA0, ack); send_byte(8'h40, ack); send_byte(8'hAA, ack);
    start_c; send_byte(8'hA0, ack); send_byte(8'h40, ack);
    start_c; send_byte(8'hA1, ack); recv_byte(1'b0, b);
    check("R6 aborted write kept old byte", b, 8'h5C);
    stop_c;
    start_c; send_byte(8'hA0, ack); check("R6 no busy after abort", {7'd0, ack}, 8'h00); stop_c;

    // R10: busy poll right after write stop, then ready
    write1(8'h20, 8'h96, "R10 write");
    start_c; send_byte(8'hA0, ack); check("R10 nack while busy", {7'd0, ack}, 8'h01); stop_c;
    tick(WC);
    start_c; send_byte(8'hA0, ack); check("R10 ack after write cycle", {7'd0, ack}, 8'h00); stop_c;
    read1(8'h20, 8'h96, "R10 committed byte");

    // R9 wrap on write and read, R8 sequential read with master ack
    start_c; send_byte(8'hA0, ack); send_byte(8'hFF, ack);
    send_byte(8'hA1, ack); send_byte(8'hA2, ack); check("R9 second data ack", {7'd0, ack}, 8'h00);
    stop_c; tick(WC + 50);
    start_c; send_byte(8'hA0, ack); send_byte(8'hFF, ack);
    start_c; send_byte(8'hA1, ack);
    recv_byte(1'b1, b); check("R8 first byte", b, 8'hA1);
    recv_byte(1'b0, b); check("R9 wrapped byte at 0", b, 8'hA2);
    tick(8); check("R8 released after master nack", {7'd0, sda_line}, 8'h01);
    stop_c;

    // R11: stop in the middle of a data byte aborts
    start_c; send_byte(8'hA0, ack); send_byte(8'h03, ack);
    for (int i = 0; i < 4; i++) begin
      scl = 1'b0; tick(5); sda_m = 1'b1; tick(5); scl = 1'b1; tick(10);
    end
    stop_c;
    start_c; send_byte(8'hA0, ack); check("R11 mid-byte stop no busy", {7'd0, ack}, 8'h00); stop_c;
    read1(8'h03, 8'h3C, "R11 mid-byte stop no write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule